// File: doc/BRIEF.md
# Multi-Queue Shared Write Port Selector

This block is the common write side of a buffer split into four logical queues. Each queue has its own write pointer. A 5-bit write address carries two fields: a device field, which is compared against a static 3-bit identity, and a queue field. On any rising clock edge where address enable is high and the device field matches, the block latches a new target queue. Write data, qualified by an active-low write enable, is turned into a one-cycle memory write strobe. The strobe carries an address formed from the queue number and that queue's pointer, together with the captured data. Up to eight such blocks can share one address bus, each with a different identity.

Changing queue is pipelined so the bus never goes idle. On the selection edge and on the edge after it, writes still land in the previous queue. The active-low full flag turns to the new queue after the first edge. Data reaches the new queue from the second edge on. A selection controller with three named states tracks this:
- `ST_NONE`: no queue is owned.
- `ST_HOLD`: a queue is owned.
- `ST_SWAP`: a selection is in flight.

The transitions are:
- `ST_NONE` or `ST_HOLD` go to `ST_SWAP` on any address-enable edge.
- `ST_SWAP` goes to `ST_HOLD` if the latched identity matched.
- `ST_SWAP` goes to `ST_NONE` if it did not.
- Without address enable, `ST_NONE` and `ST_HOLD` stay where they are.

A selection that arrives while in `ST_SWAP` is rejected and flagged.

Top module: `mq_wport`

## Requirements
- R1: Address bits [1:0] give the queue number (0 to 3). Bits [4:2] are compared against `dev_id`. A selection with a mismatching device field leaves the block owning no queue.
- R2: A queue is selected on a rising edge where `addr_en` is 1, regardless of `wr_en_n` on that edge.
- R3: Once owned, a queue stays selected until the next accepted selection. A single selection edge is enough.
- R4: On the selection edge and on the following edge, writes with `wr_en_n` = 0 go to the previously owned queue.
- R5: `full_n` is active low. From the first rising edge after a selection it reflects `q_full` of the newly selected queue. It is 0 while no queue is owned.
- R6: From the second rising edge after a selection, writes with `wr_en_n` = 0 go to the new queue.
- R7: A write is blocked when `q_full` of the owned queue is 1 on that edge.
- R8: A write is blocked when no queue has been owned since reset, or after a selection whose device field mismatched.
- R9: An `addr_en` edge that comes one edge after an accepted selection is ignored. `sel_err` is then 1 for exactly the cycle after that edge.
- R10: An accepted write on an edge sets `mem_we` to 1 for the following cycle. In that cycle `mem_addr` = {queue[1:0], pointer[3:0]} and `mem_data` = the captured `din`. The queue's pointer then increments by one and wraps from 15 to 0.
- R11: After reset `mem_we` = 0, `sel_err` = 0, `full_n` = 0, and every queue pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr | input | 5 | Device field [4:2] and queue field [1:0] |
| addr_en | input | 1 | Selection strobe |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data |
| dev_id | input | 3 | Static identity of this block |
| q_full | input | 4 | Full status per queue |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 6 | Queue number and pointer |
| mem_data | output | 18 | Data to store |
| full_n | output | 1 | Active-low full flag of the owned queue |
| sel_err | output | 1 | Early-selection error pulse |

## Verification
The hardest situation to reach is a queue change in the middle of an unbroken write stream. In that case the flag has already turned to the new queue while the data still lands in the old one. The stimulus holds `wr_en_n` low across the selection edge and the two edges after it. It also makes the new queue full while the old one is not, so that a flag or data path switched one edge early or late shows up at once. A back-to-back selection pair is driven inside the same stream to confirm that the second one leaves both the pipeline and the data routing untouched.

// File: rtl/mq_wport_pkg.sv
package mq_wport_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_HOLD = 2'd1,
        ST_SWAP = 2'd2
    } sel_state_t;

endpackage

// File: rtl/mq_addr_decode.sv
module mq_addr_decode #(
    parameter int DEV_W  = 3,
    parameter int QSEL_W = 2
) (
    input  logic [DEV_W+QSEL_W-1:0] addr,
    input  logic [DEV_W-1:0]        dev_id,
    output logic                    hit,
    output logic [QSEL_W-1:0]       qsel
);

    localparam int AW = DEV_W + QSEL_W;

    always_comb begin
        hit  = (addr[AW-1:QSEL_W] == dev_id);
        qsel = addr[QSEL_W-1:0];
    end

endmodule

// File: rtl/mq_sel_fsm.sv
module mq_sel_fsm
    import mq_wport_pkg::*;
#(
    parameter int QSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_req,
    input  logic              sel_hit,
    input  logic [QSEL_W-1:0] sel_q,
    output logic              cur_vld,
    output logic [QSEL_W-1:0] cur_q,
    output logic              sel_err
);

    sel_state_t        state_r, state_nx;
    logic [QSEL_W-1:0] pend_q;
    logic              pend_vld;
    logic              take_sel;

    assign take_sel = sel_req && (state_r != ST_SWAP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_NONE;
        else        state_r <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_NONE: if (sel_req) state_nx = ST_SWAP;
            ST_HOLD: if (sel_req) state_nx = ST_SWAP;
            ST_SWAP: state_nx = pend_vld ? ST_HOLD : ST_NONE;
            default: state_nx = ST_NONE;
        endcase
    end

    // held selection and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_vld <= 1'b0;
            cur_q    <= '0;
            cur_vld  <= 1'b0;
            sel_err  <= 1'b0;
        end else begin
            sel_err <= sel_req && (state_r == ST_SWAP);
            if (take_sel) begin
                pend_q   <= sel_q;
                pend_vld <= sel_hit;
            end
            if (state_r == ST_SWAP) begin
                cur_q   <= pend_q;
                cur_vld <= pend_vld;
            end
        end
    end

    // R9
    early_sel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == ST_SWAP && sel_req) |=> sel_err);

    // R3
    hold_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == ST_HOLD && !sel_req) |=> ($stable(cur_q) && cur_vld));

    // R4
    swap_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r != ST_SWAP && sel_req) |=> ($stable(cur_q) && $stable(cur_vld)));

endmodule

// File: rtl/mq_wptr_bank.sv
module mq_wptr_bank #(
    parameter int NQ     = 4,
    parameter int PTR_W  = 4,
    parameter int DATA_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cur_vld,
    input  logic [$clog2(NQ)-1:0]     cur_q,
    input  logic                      wr_en_n,
    input  logic [DATA_W-1:0]         din,
    input  logic [NQ-1:0]             q_full,
    output logic                      mem_we,
    output logic [$clog2(NQ)+PTR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]         mem_data
);

    localparam int QSEL_W = $clog2(NQ);

    logic [PTR_W-1:0] ptr [NQ];
    logic             wr_go;

    assign wr_go = !wr_en_n && cur_vld && !q_full[cur_q];

    for (genvar gi = 0; gi < NQ; gi++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr[gi] <= '0;
            else if (wr_go && (cur_q == QSEL_W'(gi)))
                ptr[gi] <= ptr[gi] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= wr_go;
            if (wr_go) begin
                mem_addr <= {cur_q, ptr[cur_q]};
                mem_data <= din;
            end
        end
    end

    // R7
    no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_vld && q_full[cur_q]) |=> !mem_we);

    // R8
    no_owner_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_vld |=> !mem_we);

endmodule

// File: rtl/mq_wport.sv
module mq_wport #(
    parameter int NQ     = 4,
    parameter int DEV_W  = 3,
    parameter int PTR_W  = 4,
    parameter int DATA_W = 18,
    localparam int QSEL_W = $clog2(NQ),
    localparam int AW     = DEV_W + QSEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           wr_addr,
    input  logic                    addr_en,
    input  logic                    wr_en_n,
    input  logic [DATA_W-1:0]       din,
    input  logic [DEV_W-1:0]        dev_id,
    input  logic [NQ-1:0]           q_full,
    output logic                    mem_we,
    output logic [QSEL_W+PTR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_data,
    output logic                    full_n,
    output logic                    sel_err
);

    logic              dec_hit;
    logic [QSEL_W-1:0] dec_q;
    logic              cur_vld;
    logic [QSEL_W-1:0] cur_q;

    mq_addr_decode #(.DEV_W(DEV_W), .QSEL_W(QSEL_W)) u_dec (
        .addr   (wr_addr),
        .dev_id (dev_id),
        .hit    (dec_hit),
        .qsel   (dec_q)
    );

    mq_sel_fsm #(.QSEL_W(QSEL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_req (addr_en),
        .sel_hit (dec_hit),
        .sel_q   (dec_q),
        .cur_vld (cur_vld),
        .cur_q   (cur_q),
        .sel_err (sel_err)
    );

    mq_wptr_bank #(.NQ(NQ), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_vld  (cur_vld),
        .cur_q    (cur_q),
        .wr_en_n  (wr_en_n),
        .din      (din),
        .q_full   (q_full),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data)
    );

    assign full_n = cur_vld && !q_full[cur_q];

    // R5
    flag_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_vld |-> !full_n);

endmodule

// File: tb/tb_mq_wport.sv
`timescale 1ns/100ps
module tb_mq_wport;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        addr_en = 1'b0;
    logic        wr_en_n = 1'b1;
    logic [17:0] din = '0;
    logic [2:0]  dev_id = 3'd5;
    logic [3:0]  q_full = '0;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [17:0] mem_data;
    logic        full_n;
    logic        sel_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R11 reset";

    // reference model state
    int    m_cur = -1;
    int    m_pend = -1;
    bit    m_swap = 1'b0;
    int    m_ptr [4];
    bit    e_we = 1'b0;
    int    e_addr = 0;
    int    e_data = 0;
    bit    e_err = 1'b0;

    always #2.5 clk = ~clk;

    mq_wport dut (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .addr_en(addr_en),
        .wr_en_n(wr_en_n), .din(din), .dev_id(dev_id), .q_full(q_full),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .full_n(full_n), .sel_err(sel_err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = -1; m_pend = -1; m_swap = 1'b0;
            for (int i = 0; i < 4; i++) m_ptr[i] = 0;
            e_we = 1'b0; e_err = 1'b0;
        end else begin
            if (!wr_en_n && m_cur >= 0 && !q_full[m_cur]) begin
                e_we   = 1'b1;
                e_addr = m_cur * 16 + m_ptr[m_cur];
                e_data = din;
                m_ptr[m_cur] = (m_ptr[m_cur] + 1) % 16;
            end else begin
                e_we = 1'b0;
            end
            e_err = addr_en && m_swap;
            if (m_swap) begin
                m_cur  = m_pend;
                m_swap = 1'b0;
            end else if (addr_en) begin
                m_pend = (wr_addr[4:2] == dev_id) ? int'(wr_addr[1:0]) : -1;
                m_swap = 1'b1;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("full_n", full_n, (m_cur >= 0) ? !q_full[m_cur] : 0);
            chk("mem_we", mem_we, e_we);
            chk("sel_err", sel_err, e_err);
            if (e_we) begin
                chk("mem_addr", mem_addr, e_addr);
                chk("mem_data", mem_data, e_data);
            end
        end
    end

    task automatic cyc(input bit aen, input logic [4:0] adr,
                       input bit wen, input logic [17:0] d);
        @(posedge clk); #1;
        addr_en = aen; wr_addr = adr; wr_en_n = wen; din = d;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(0, 0, 1, 0);
        // R8: writes before any selection are blocked
        tag = "R8 no-owner";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 18'h100 + i);
        // R1 R2: select queue 2 while write enable is high
        tag = "R1 R2 select";
        cyc(1, {3'd5, 2'd2}, 1, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        // R3: queue stays owned across many writes
        tag = "R3 hold";
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 18'h200 + i);
        // R4 R6: switch to queue 1 during an unbroken stream
        tag = "R4 R6 switch";
        cyc(1, {3'd5, 2'd1}, 0, 18'h301);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 18'h310 + i);
        // R5: new queue full while old is not
        tag = "R5 flag";
        q_full = 4'b1000;
        cyc(1, {3'd5, 2'd3}, 0, 18'h401);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 18'h410 + i);
        // R7: release and set full on the owned queue
        tag = "R7 full";
        q_full = 4'b0000;
        cyc(0, 0, 0, 18'h501);
        q_full = 4'b1000;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 18'h510 + i);
        q_full = 4'b0000;
        cyc(0, 0, 0, 18'h520);
        // R9: back-to-back selection, second ignored
        tag = "R9 early";
        cyc(1, {3'd5, 2'd0}, 0, 18'h601);
        cyc(1, {3'd5, 2'd2}, 0, 18'h602);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 18'h610 + i);
        // R8 R1: mismatching device field drops ownership
        tag = "R8 R1 mismatch";
        cyc(1, {3'd2, 2'd1}, 0, 18'h701);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 18'h710 + i);
        // R10: pointer wrap on queue 0
        tag = "R10 wrap";
        cyc(1, {3'd5, 2'd0}, 1, 0);
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 18'h800 + i);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        @(posedge clk); #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule